// File: doc/BRIEF.md
# Ternary Rule Loader Controller

This block prepares a ternary match store before any search runs. A one-cycle start request comes with a rule width in bits and a rule count. The controller latches both, checks them against the legal widths, the build-time rule-count exponent and the capacity of the local store, and then, if everything is legal, fetches every rule byte from an external rule memory. Each fetched word is 9 bits wide. It is decoded into an 8-bit literal or a whole-byte wildcard, then handed to the store through a valid/ready write port.

The memory read port holds a request and its address until the memory answers with a single-cycle valid pulse, so any memory latency works. The store write port applies back-pressure: an offered word stays on the port, unchanged, until ready is seen high on a clock edge. The next memory read is not issued before that. While it works the controller raises busy. When it stops it posts a 4-bit status code one cycle before busy falls, and keeps that code until the next start. Status codes: 0 none yet, 1 success, 2 rule count too large, 3 pattern or capacity overflow, 4 unsupported width, 5 rule-count exponent outside 16..20.

Top module: `rule_loader_ctrl`

## Requirements
- R1: Width and count are captured on the clock edge where the start request is seen while idle. Changes on those pins while busy have no effect on addresses, written data or the final status.
- R2: Busy is high from the clock edge after an accepted start until the edge after the final status is posted. A start request while busy is ignored.
- R3: Status is 0 after reset and is cleared to 0 at each accepted start. The final code is present for at least one cycle with busy still high, and it is held after busy falls until the next start.
- R4: Legal widths are 24, 32, 40, 48, 56 and 64. Any other value ends with status 4.
- R5: With a legal width, a count greater than 2^MAX_RULE ends with status 2.
- R6: With legal width and count, count*(width/8) greater than STORE_WORDS ends with status 3, before any read.
- R7: If MAX_RULE is below 16 or above 20, every start ends with status 5. Checks take priority in the order 5, 4, 2, 3.
- R8: A configuration that fails a check issues no memory request.
- R9: Read request and address rise together and are held unchanged until mem_valid. Addresses run 0, 1, 2, ... up to count*(width/8)-1.
- R10: A word of 0..255 is written with dc=0 and value equal to the word. A word of 256 is written with dc=1 and value 0. A word above 256 stops the load with status 3 and is not written; earlier words stay written.
- R11: Memory word n*(width/8)+k is written as rule n, lane k, where lane 0 is the most significant key byte.
- R12: An offered store write keeps valid and all its fields stable until ready is high on a clock edge. No read request is raised while a write is pending.
- R13: A full load of all words, or a count of 0 (no reads), ends with status 1.
- R14: A new start after an error end runs the whole sequence again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_req | input | 1 | Start request |
| cfg_width | input | 16 | Rule width in bits |
| cfg_count | input | 32 | Number of rules |
| busy | output | 1 | Load in progress |
| status | output | 4 | Completion code |
| mem_req | output | 1 | Rule memory read request |
| mem_addr | output | 32 | Rule memory word address |
| mem_valid | input | 1 | Single-cycle read data valid |
| mem_data | input | 9 | Rule memory word |
| st_wr_valid | output | 1 | Store write offered |
| st_wr_ready | input | 1 | Store accepts write |
| st_wr_rule | output | 32 | Rule index |
| st_wr_lane | output | 3 | Key byte lane, 0 is MSB |
| st_wr_value | output | 8 | Literal byte |
| st_wr_dc | output | 1 | Byte is wildcard |

## Verification
Two kinds of event can fall in the same cycle: a second start request arriving while a load is already running, and changes on the width and count pins during a load. The bench raises a fresh start, with different width and count on the pins, on the first cycle of every busy period. This is also the cycle in which the error paths post their status. The run is judged correct when the address stream, the scoreboarded store writes and the final status all match the first configuration. Store back-pressure is also applied at random while memory latency varies, so that accepted writes and read returns interleave with stalls.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int WORD_W = 9;

  localparam logic [3:0] ST_NONE    = 4'd0;
  localparam logic [3:0] ST_OK      = 4'd1;
  localparam logic [3:0] ST_COUNT   = 4'd2;
  localparam logic [3:0] ST_PATTERN = 4'd3;
  localparam logic [3:0] ST_WIDTH   = 4'd4;
  localparam logic [3:0] ST_RANGE   = 4'd5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_READ,
    S_WRITE,
    S_FIN
  } rl_state_e;
endpackage

// File: rtl/rl_cfg_check.sv
module rl_cfg_check #(
  parameter int MAX_RULE    = 16,
  parameter int STORE_WORDS = 4096
) (
  input  logic [15:0] width,
  input  logic [31:0] count,
  output logic [3:0]  err_code,
  output logic [3:0]  bpr,
  output logic [35:0] total
);
  import rl_pkg::*;

  localparam bit          RANGE_OK = (MAX_RULE >= 16) && (MAX_RULE <= 20);
  localparam logic [32:0] LIMIT    = 33'd1 << MAX_RULE;
  localparam logic [35:0] CAP      = 36'(STORE_WORDS);

  logic width_ok;

  always_comb begin
    case (width)
      16'd24, 16'd32, 16'd40, 16'd48, 16'd56, 16'd64: width_ok = 1'b1;
      default:                                         width_ok = 1'b0;
    endcase
    bpr   = width_ok ? width[6:3] : 4'd0;
    total = 36'(count) * 36'(bpr);
  end

  generate
    if (!RANGE_OK) begin : g_bad_range
      assign err_code = ST_RANGE;
    end else begin : g_checks
      always_comb begin
        if (!width_ok)                 err_code = ST_WIDTH;
        else if ({1'b0, count} > LIMIT) err_code = ST_COUNT;
        else if (total > CAP)           err_code = ST_PATTERN;
        else                            err_code = ST_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/rl_word_decode.sv
module rl_word_decode (
  input  logic [rl_pkg::WORD_W-1:0] word,
  output logic [7:0]                value,
  output logic                      dc,
  output logic                      bad
);
  always_comb begin
    bad   = word > 9'd256;
    dc    = word == 9'd256;
    value = (dc || bad) ? 8'd0 : word[7:0];
  end
endmodule

// File: rtl/rl_seq.sv
module rl_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic [15:0] cfg_width,
  input  logic [31:0] cfg_count,
  output logic [15:0] width_q,
  output logic [31:0] count_q,
  input  logic [3:0]  err_code,
  input  logic [3:0]  bpr,
  input  logic [35:0] total,
  input  logic        mem_valid,
  input  logic [7:0]  dec_value,
  input  logic        dec_dc,
  input  logic        dec_bad,
  output logic        busy,
  output logic [3:0]  status,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic        st_wr_valid,
  input  logic        st_wr_ready,
  output logic [31:0] st_wr_rule,
  output logic [2:0]  st_wr_lane,
  output logic [7:0]  st_wr_value,
  output logic        st_wr_dc
);
  import rl_pkg::*;

  rl_state_e   state_q;
  logic        busy_q;
  logic [3:0]  status_q;
  logic [31:0] addr_q;
  logic [31:0] rule_q;
  logic [2:0]  lane_q;
  logic [7:0]  val_q;
  logic        dc_q;
  logic        last_lane;
  logic        last_word;

  assign last_lane = {1'b0, lane_q} == (bpr - 4'd1);
  assign last_word = (36'(addr_q) + 36'd1) == total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      busy_q   <= 1'b0;
      status_q <= ST_NONE;
      width_q  <= '0;
      count_q  <= '0;
      addr_q   <= '0;
      rule_q   <= '0;
      lane_q   <= '0;
      val_q    <= '0;
      dc_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (init_req) begin
            width_q  <= cfg_width;
            count_q  <= cfg_count;
            busy_q   <= 1'b1;
            status_q <= ST_NONE;
            addr_q   <= '0;
            rule_q   <= '0;
            lane_q   <= '0;
            state_q  <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (err_code != ST_NONE) begin
            status_q <= err_code;
            state_q  <= S_FIN;
          end else if (total == 36'd0) begin
            status_q <= ST_OK;
            state_q  <= S_FIN;
          end else begin
            state_q  <= S_READ;
          end
        end
        S_READ: begin
          if (mem_valid) begin
            if (dec_bad) begin
              status_q <= ST_PATTERN;
              state_q  <= S_FIN;
            end else begin
              val_q   <= dec_value;
              dc_q    <= dec_dc;
              state_q <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (st_wr_ready) begin
            addr_q <= addr_q + 32'd1;
            if (last_lane) begin
              lane_q <= '0;
              rule_q <= rule_q + 32'd1;
            end else begin
              lane_q <= lane_q + 3'd1;
            end
            if (last_word) begin
              status_q <= ST_OK;
              state_q  <= S_FIN;
            end else begin
              state_q  <= S_READ;
            end
          end
        end
        S_FIN: begin
          busy_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = busy_q;
  assign status      = status_q;
  assign mem_req     = state_q == S_READ;
  assign mem_addr    = addr_q;
  assign st_wr_valid = state_q == S_WRITE;
  assign st_wr_rule  = rule_q;
  assign st_wr_lane  = lane_q;
  assign st_wr_value = val_q;
  assign st_wr_dc    = dc_q;

  // R9: request and address held until memory answers
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R12: offered write is frozen under back-pressure
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_valid && !st_wr_ready |=> st_wr_valid && $stable(st_wr_value)
      && $stable(st_wr_dc) && $stable(st_wr_rule) && $stable(st_wr_lane));

  // R12: no read while a write is pending
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && st_wr_valid));

  // R3: final code posted before busy falls
  a_r3_code_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status != ST_NONE) && $stable(status));

  // R2: busy only rises after a start request
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(init_req));

  // R8: a failed check never reaches the memory
  a_r8_no_read_bad_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> err_code == ST_NONE);
endmodule

// File: rtl/rule_loader_ctrl.sv
module rule_loader_ctrl #(
  parameter int MAX_RULE    = 16,
  parameter int STORE_WORDS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic [15:0] cfg_width,
  input  logic [31:0] cfg_count,
  output logic        busy,
  output logic [3:0]  status,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [8:0]  mem_data,
  output logic        st_wr_valid,
  input  logic        st_wr_ready,
  output logic [31:0] st_wr_rule,
  output logic [2:0]  st_wr_lane,
  output logic [7:0]  st_wr_value,
  output logic        st_wr_dc
);
  logic [15:0] width_q;
  logic [31:0] count_q;
  logic [3:0]  err_code;
  logic [3:0]  bpr;
  logic [35:0] total;
  logic [7:0]  dec_value;
  logic        dec_dc;
  logic        dec_bad;

  rl_cfg_check #(
    .MAX_RULE    (MAX_RULE),
    .STORE_WORDS (STORE_WORDS)
  ) u_check (
    .width    (width_q),
    .count    (count_q),
    .err_code (err_code),
    .bpr      (bpr),
    .total    (total)
  );

  rl_word_decode u_decode (
    .word  (mem_data),
    .value (dec_value),
    .dc    (dec_dc),
    .bad   (dec_bad)
  );

  rl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .cfg_width   (cfg_width),
    .cfg_count   (cfg_count),
    .width_q     (width_q),
    .count_q     (count_q),
    .err_code    (err_code),
    .bpr         (bpr),
    .total       (total),
    .mem_valid   (mem_valid),
    .dec_value   (dec_value),
    .dec_dc      (dec_dc),
    .dec_bad     (dec_bad),
    .busy        (busy),
    .status      (status),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .st_wr_valid (st_wr_valid),
    .st_wr_ready (st_wr_ready),
    .st_wr_rule  (st_wr_rule),
    .st_wr_lane  (st_wr_lane),
    .st_wr_value (st_wr_value),
    .st_wr_dc    (st_wr_dc)
  );
endmodule

// File: tb/rule_loader_ctrl_tb_top.sv
`timescale 1ns/1ps
module rule_loader_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic [15:0] cfg_width = '0;
  logic [31:0] cfg_count = '0;
  logic        busy;
  logic [3:0]  status;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [8:0]  mem_data = '0;
  logic        st_wr_valid;
  logic        st_wr_ready = 1'b1;
  logic [31:0] st_wr_rule;
  logic [2:0]  st_wr_lane;
  logic [7:0]  st_wr_value;
  logic        st_wr_dc;

  logic        r_init = 1'b0;
  logic        r_busy;
  logic [3:0]  r_status;
  logic        r_req;
  logic [31:0] r_addr;
  logic        r_wv;
  logic [31:0] r_rule;
  logic [2:0]  r_lane;
  logic [7:0]  r_val;
  logic        r_dc;

  always #4 clk = ~clk;

  rule_loader_ctrl #(.MAX_RULE(16), .STORE_WORDS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .cfg_width(cfg_width),
    .cfg_count(cfg_count), .busy(busy), .status(status), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready), .st_wr_rule(st_wr_rule),
    .st_wr_lane(st_wr_lane), .st_wr_value(st_wr_value), .st_wr_dc(st_wr_dc));

  rule_loader_ctrl #(.MAX_RULE(21), .STORE_WORDS(64)) dut_range_i (
    .clk(clk), .rst_n(rst_n), .init_req(r_init), .cfg_width(16'd32),
    .cfg_count(32'd2), .busy(r_busy), .status(r_status), .mem_req(r_req),
    .mem_addr(r_addr), .mem_valid(1'b0), .mem_data(9'd0),
    .st_wr_valid(r_wv), .st_wr_ready(1'b1), .st_wr_rule(r_rule),
    .st_wr_lane(r_lane), .st_wr_value(r_val), .st_wr_dc(r_dc));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [8:0]  mem [0:127];
  logic [43:0] exp_q [$];
  int          lat = 0;
  int          lat_cnt = 0;
  bit          stall_mode = 1'b0;
  int          reads = 0;
  int          writes = 0;
  int          exp_addr = 0;
  bit          hold_pend = 1'b0;
  logic [43:0] hold_item;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // memory responder, store ready driver and write monitor
  initial begin
    forever begin
      @(negedge clk);
      st_wr_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      if (mem_valid) begin
        mem_valid = 1'b0;
      end else if (mem_req) begin
        if (lat_cnt >= lat) begin
          check(mem_addr == 32'(exp_addr), "R9 read address order", mem_addr, exp_addr);
          mem_data  = mem[mem_addr[6:0]];
          mem_valid = 1'b1;
          lat_cnt   = 0;
          reads++;
          exp_addr++;
        end else begin
          lat_cnt++;
        end
      end
      if (hold_pend) begin
        check(st_wr_valid && {st_wr_rule, st_wr_lane, st_wr_dc, st_wr_value} == hold_item,
              "R12 write held under stall", {st_wr_rule, st_wr_lane, st_wr_dc, st_wr_value}, hold_item);
        hold_pend = 1'b0;
      end
      if (st_wr_valid && st_wr_ready) begin
        writes++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected store write", st_wr_value, -1);
        end else begin
          logic [43:0] e;
          e = exp_q.pop_front();
          check({st_wr_rule, st_wr_lane, st_wr_dc, st_wr_value} == e, "R10 R11 store write",
                {st_wr_rule, st_wr_lane, st_wr_dc, st_wr_value}, e);
        end
      end else if (st_wr_valid) begin
        hold_pend = 1'b1;
        hold_item = {st_wr_rule, st_wr_lane, st_wr_dc, st_wr_value};
      end
    end
  end

  // push expected writes; returns expected read count
  task automatic push_expected(input int width, input int count, output int nreads, output bit badw);
    int bpr = width / 8;
    nreads = 0;
    badw = 1'b0;
    for (int n = 0; n < count && !badw; n++) begin
      for (int k = 0; k < bpr && !badw; k++) begin
        logic [8:0] w = mem[n * bpr + k];
        nreads++;
        if (w > 9'd256) badw = 1'b1;
        else if (w == 9'd256) exp_q.push_back({32'(n), 3'(k), 1'b1, 8'd0});
        else exp_q.push_back({32'(n), 3'(k), 1'b0, w[7:0]});
      end
    end
  endtask

  task automatic run_init(input int width, input int count, input int latency,
                          input bit stall, input bit legal, input logic [3:0] exp_st, input string tag);
    int  nreads;
    bit  badw;
    logic [3:0] prev_st;
    int  guard;
    exp_q.delete();
    nreads = 0;
    if (legal) push_expected(width, count, nreads, badw);
    reads = 0; writes = 0; exp_addr = 0; lat = latency; lat_cnt = 0; stall_mode = stall;
    @(negedge clk);
    cfg_width = 16'(width);
    cfg_count = 32'(count);
    init_req  = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
    check(status == 4'd0, {tag, " R3 status cleared at start"}, status, 0);
    // same-cycle stress: a fresh start and new config while busy
    cfg_width = 16'd64;
    cfg_count = 32'd1;
    init_req  = 1'b1;
    @(negedge clk);
    init_req  = 1'b0;
    cfg_width = 16'd7;
    cfg_count = 32'hFFFF_FFFF;
    prev_st = status;
    guard = 0;
    while (busy && guard < 5000) begin
      prev_st = status;
      @(negedge clk);
      guard++;
    end
    check(prev_st == exp_st, {tag, " R3 code before busy falls"}, prev_st, exp_st);
    check(status == exp_st, {tag, " final status R1 R2"}, status, exp_st);
    check(reads == nreads, {tag, " R8 R9 read count"}, reads, nreads);
    check(exp_q.size() == 0, {tag, " R10 all writes seen"}, exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check(status == exp_st && !busy, {tag, " R3 status held"}, status, exp_st);
    stall_mode = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = ((i % 7) == 3) ? 9'd256 : 9'((i * 37 + 11) % 256);
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && status == 4'd0, "R3 reset status", status, 0);
    check(!mem_req && !st_wr_valid, "R8 reset no traffic", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_init(32, 3, 0, 1'b0, 1'b1, 4'd1, "R13 w32");
    run_init(64, 2, 3, 1'b1, 1'b1, 4'd1, "R12 w64 stall");
    run_init(24, 5, 1, 1'b1, 1'b1, 4'd1, "R11 w24");
    run_init(56, 1, 2, 1'b0, 1'b1, 4'd1, "R4 w56");
    run_init(33, 2, 0, 1'b0, 1'b0, 4'd4, "R4 bad width");
    run_init(33, 70000, 0, 1'b0, 1'b0, 4'd4, "R7 priority width");
    run_init(24, 65537, 0, 1'b0, 1'b0, 4'd2, "R5 count");
    run_init(24, 65536, 0, 1'b0, 1'b0, 4'd3, "R6 edge count");
    run_init(64, 9, 0, 1'b0, 1'b0, 4'd3, "R6 capacity");
    run_init(64, 8, 0, 1'b0, 1'b1, 4'd1, "R6 exact fit");
    run_init(40, 0, 0, 1'b0, 1'b1, 4'd1, "R13 zero count");
    mem[5] = 9'd300;
    run_init(32, 3, 1, 1'b1, 1'b1, 4'd3, "R10 bad word");
    mem[5] = 9'd48;
    run_init(48, 2, 2, 1'b0, 1'b1, 4'd1, "R14 restart");

    @(negedge clk);
    r_init = 1'b1;
    @(negedge clk);
    r_init = 1'b0;
    repeat (4) @(negedge clk);
    check(r_status == 4'd5 && !r_busy, "R7 exponent out of range", r_status, 5);
    check(!r_req && !r_wv, "R8 range error no traffic", r_req, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule